// File: doc/BRIEF.md
# Compute Dispatch Invocation ID Generator

This block walks every invocation of a compute dispatch that has up to three dimensions. A start strobe loads three values: a work-group size (x,y,z), a work-group count (x,y,z) and a dimensionality selector. The block then emits one invocation per accepted handshake cycle. Each emitted invocation carries its position inside its work group, the position of its work group in the dispatch, its position in the whole dispatch, and its flattened index within the group. The group size and group count of the dispatch travel alongside.

A downstream consumer takes the stream over a valid/ready handshake. After the last invocation has been accepted, the block raises a single-cycle done pulse. Dimensions that the selector leaves unused are forced before the walk starts: their ids are reported as zero, and their size and count as one. A dispatch with an empty dimension finishes at once and emits nothing.

Top module: `dispatch_id_gen`

## Requirements
- R1: After reset, `outValid` and `done` are low.
- R2: Invocations of one work group are all emitted before those of the next group. Within a group the local id steps x fastest, then y, then z. Groups are walked in the same x, y, z order, starting at all-zero ids.
- R3: Each component of `globalId` equals groupId times groupSize plus localId in that dimension.
- R4: `localIndex` equals localId.z*size.x*size.y + localId.y*size.x + localId.x.
- R5: `cfgDims` encoding: 2'd1 is one-dimensional, 2'd2 is two-dimensional, and 2'd0 or 2'd3 is three-dimensional. The unused y (1D) and z (1D, 2D) components of the ids are zero, and the same components of `groupSize` and `groupCount` read one, whatever is on the inputs.
- R6: `groupSize` and `groupCount` stay constant over all invocations of a dispatch.
- R7: While `outValid` is high and `outReady` is low, all outputs hold their values.
- R8: `done` is high for exactly one cycle, in the cycle after the last invocation is accepted, and `outValid` is low then. The number of accepted invocations equals the product of the effective sizes and counts.
- R9: If any effective size or count component is zero, `done` rises in the cycle after start and no invocation is emitted.
- R10: A start strobe while a dispatch is in progress is ignored, together with its configuration.
- R11: Packed vectors hold x in the lowest field, then y, then z.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| start | input | 1 | Begin a dispatch (sampled only when idle) |
| cfgDims | input | 2 | Dimensionality selector |
| cfgSize | input | 3*DIM_W | Work-group size, x/y/z |
| cfgCount | input | 3*DIM_W | Work-group count, x/y/z |
| outReady | input | 1 | Consumer accepts the current invocation |
| outValid | output | 1 | An invocation is presented |
| localId | output | 3*DIM_W | Offset within the work group |
| groupId | output | 3*DIM_W | Work-group offset in groups |
| globalId | output | 6*DIM_W | Offset within the dispatch |
| groupSize | output | 3*DIM_W | Effective work-group size |
| groupCount | output | 3*DIM_W | Effective work-group count |
| localIndex | output | 3*DIM_W | Flattened index within the group |
| done | output | 1 | One-cycle end-of-dispatch pulse |

## Verification
The bench builds the block with DIM_W=4, which allows up to 15 per component. With that width, complete walks of realistic shapes stay short. One of them is an 8x4 group on a 5x4 grid, which contains the invocation at global (10,9) with local (2,1) and group (1,2). Every emitted invocation is compared with values computed arithmetically, under both steady and irregular ready patterns. The small width also makes the empty-dimension, single-invocation and reduced-dimension cases cheap to cover, including the case of garbage on the unused inputs.

// File: rtl/dispatch_id_pkg.sv
package dispatch_id_pkg;

  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_RUN  = 2'd1,
    ST_FIN  = 2'd2
  } walkState_t;

  // strobes from control to datapath
  typedef struct packed {
    logic load;
    logic step;
  } walkCtl_t;

  localparam logic [1:0] DIMS_ONE = 2'd1;
  localparam logic [1:0] DIMS_TWO = 2'd2;

endpackage

// File: rtl/dispatch_id_ctrl.sv
module dispatch_id_ctrl
  import dispatch_id_pkg::*;
(
  input  logic     clk,
  input  logic     rstN,
  input  logic     start,
  input  logic     outReady,
  input  logic     cfgZero,
  input  logic     lastInv,
  output walkCtl_t ctl,
  output logic     outValid,
  output logic     done
);

  walkState_t state, stateNext;

  always_comb begin
    stateNext = state;
    ctl.load  = 1'b0;
    ctl.step  = 1'b0;
    unique case (state)
      ST_IDLE: if (start) begin
        ctl.load  = 1'b1;
        stateNext = cfgZero ? ST_FIN : ST_RUN;
      end
      ST_RUN: if (outReady) begin
        ctl.step = 1'b1;
        if (lastInv) stateNext = ST_FIN;
      end
      ST_FIN:  stateNext = ST_IDLE;
      default: stateNext = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rstN) state <= ST_IDLE;
    else       state <= stateNext;
  end

  assign outValid = (state == ST_RUN);
  assign done     = (state == ST_FIN);

endmodule

// File: rtl/dispatch_id_dpath.sv
module dispatch_id_dpath
  import dispatch_id_pkg::*;
#(
  parameter int DIM_W = 4
) (
  input  logic                 clk,
  input  logic                 rstN,
  input  walkCtl_t             ctl,
  input  logic [1:0]           cfgDims,
  input  logic [3*DIM_W-1:0]   cfgSize,
  input  logic [3*DIM_W-1:0]   cfgCount,
  output logic                 cfgZero,
  output logic                 lastInv,
  output logic [3*DIM_W-1:0]   localId,
  output logic [3*DIM_W-1:0]   groupId,
  output logic [6*DIM_W-1:0]   globalId,
  output logic [3*DIM_W-1:0]   groupSize,
  output logic [3*DIM_W-1:0]   groupCount,
  output logic [3*DIM_W-1:0]   localIndex
);

  localparam int GW = 2 * DIM_W;
  localparam int IW = 3 * DIM_W;
  localparam logic [DIM_W-1:0] ONE = DIM_W'(1);

  logic [2:0][DIM_W-1:0] effSize, effCount;
  logic [2:0][DIM_W-1:0] sizeR, countR, lidR, gidR;
  logic [2:0] lidMax, gidMax;
  logic [3:0] lCarry, gCarry;

  // force unused dimensions to one before the zero test
  always_comb begin
    effSize  = cfgSize;
    effCount = cfgCount;
    if (cfgDims == DIMS_ONE) begin
      effSize[1] = ONE;  effCount[1] = ONE;
      effSize[2] = ONE;  effCount[2] = ONE;
    end else if (cfgDims == DIMS_TWO) begin
      effSize[2] = ONE;  effCount[2] = ONE;
    end
    cfgZero = 1'b0;
    for (int i = 0; i < 3; i++)
      if (effSize[i] == '0 || effCount[i] == '0) cfgZero = 1'b1;
  end

  // odometer carry chain: local x,y,z then group x,y,z
  always_comb begin
    lCarry[0] = 1'b1;
    for (int i = 0; i < 3; i++) begin
      lidMax[i]     = (lidR[i] == sizeR[i] - ONE);
      gidMax[i]     = (gidR[i] == countR[i] - ONE);
      lCarry[i+1]   = lCarry[i] & lidMax[i];
    end
    gCarry[0] = lCarry[3];
    for (int i = 0; i < 3; i++)
      gCarry[i+1] = gCarry[i] & gidMax[i];
    lastInv = gCarry[3];
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      sizeR  <= '0;
      countR <= '0;
      lidR   <= '0;
      gidR   <= '0;
    end else if (ctl.load) begin
      sizeR  <= effSize;
      countR <= effCount;
      lidR   <= '0;
      gidR   <= '0;
    end else if (ctl.step) begin
      for (int i = 0; i < 3; i++) begin
        if (lCarry[i]) lidR[i] <= lidMax[i] ? '0 : lidR[i] + ONE;
        if (gCarry[i]) gidR[i] <= gidMax[i] ? '0 : gidR[i] + ONE;
      end
    end
  end

  for (genvar g = 0; g < 3; g++) begin : gDim
    assign localId[g*DIM_W +: DIM_W]    = lidR[g];
    assign groupId[g*DIM_W +: DIM_W]    = gidR[g];
    assign groupSize[g*DIM_W +: DIM_W]  = sizeR[g];
    assign groupCount[g*DIM_W +: DIM_W] = countR[g];
    assign globalId[g*GW +: GW] = GW'(gidR[g]) * GW'(sizeR[g]) + GW'(lidR[g]);
  end

  assign localIndex = IW'(lidR[2]) * IW'(sizeR[0]) * IW'(sizeR[1])
                    + IW'(lidR[1]) * IW'(sizeR[0])
                    + IW'(lidR[0]);

endmodule

// File: rtl/dispatch_id_gen.sv
module dispatch_id_gen
  import dispatch_id_pkg::*;
#(
  parameter int DIM_W = 4
) (
  input  logic                 clk,
  input  logic                 rstN,
  input  logic                 start,
  input  logic [1:0]           cfgDims,
  input  logic [3*DIM_W-1:0]   cfgSize,
  input  logic [3*DIM_W-1:0]   cfgCount,
  input  logic                 outReady,
  output logic                 outValid,
  output logic [3*DIM_W-1:0]   localId,
  output logic [3*DIM_W-1:0]   groupId,
  output logic [6*DIM_W-1:0]   globalId,
  output logic [3*DIM_W-1:0]   groupSize,
  output logic [3*DIM_W-1:0]   groupCount,
  output logic [3*DIM_W-1:0]   localIndex,
  output logic                 done
);

  walkCtl_t ctl;
  logic     cfgZero, lastInv;

  dispatch_id_ctrl u_ctrl (
    .clk(clk), .rstN(rstN), .start(start), .outReady(outReady),
    .cfgZero(cfgZero), .lastInv(lastInv), .ctl(ctl),
    .outValid(outValid), .done(done)
  );

  dispatch_id_dpath #(.DIM_W(DIM_W)) u_dpath (
    .clk(clk), .rstN(rstN), .ctl(ctl), .cfgDims(cfgDims),
    .cfgSize(cfgSize), .cfgCount(cfgCount),
    .cfgZero(cfgZero), .lastInv(lastInv),
    .localId(localId), .groupId(groupId), .globalId(globalId),
    .groupSize(groupSize), .groupCount(groupCount), .localIndex(localIndex)
  );

endmodule

// File: rtl/dispatch_id_chk.sv
module dispatch_id_chk #(
  parameter int DIM_W = 4
) (
  input logic               clk,
  input logic               rstN,
  input logic               outReady,
  input logic               outValid,
  input logic               done,
  input logic [3*DIM_W-1:0] localId,
  input logic [3*DIM_W-1:0] groupId,
  input logic [3*DIM_W-1:0] groupSize,
  input logic [3*DIM_W-1:0] groupCount,
  input logic [3*DIM_W-1:0] localIndex
);

  localparam int IW = 3 * DIM_W;

  a_r7_hold: assert property (@(posedge clk) disable iff (!rstN)
    outValid && !outReady |=> outValid && $stable(localId) && $stable(groupId)
                              && $stable(localIndex));

  a_r6_const: assert property (@(posedge clk) disable iff (!rstN)
    outValid |=> !outValid || ($stable(groupSize) && $stable(groupCount)));

  a_r8_pulse: assert property (@(posedge clk) disable iff (!rstN)
    done |=> !done);

  a_r8_excl: assert property (@(posedge clk) disable iff (!rstN)
    !(done && outValid));

  a_r2_range: assert property (@(posedge clk) disable iff (!rstN)
    outValid |-> (localId[0 +: DIM_W] < groupSize[0 +: DIM_W])
              && (localId[DIM_W +: DIM_W] < groupSize[DIM_W +: DIM_W])
              && (localId[2*DIM_W +: DIM_W] < groupSize[2*DIM_W +: DIM_W])
              && (groupId[0 +: DIM_W] < groupCount[0 +: DIM_W])
              && (groupId[DIM_W +: DIM_W] < groupCount[DIM_W +: DIM_W])
              && (groupId[2*DIM_W +: DIM_W] < groupCount[2*DIM_W +: DIM_W]));

  a_r4_bound: assert property (@(posedge clk) disable iff (!rstN)
    outValid |-> localIndex < IW'(groupSize[0 +: DIM_W]) * IW'(groupSize[DIM_W +: DIM_W])
                              * IW'(groupSize[2*DIM_W +: DIM_W]));

endmodule

bind dispatch_id_gen dispatch_id_chk #(.DIM_W(DIM_W)) u_chk (
  .clk(clk), .rstN(rstN), .outReady(outReady), .outValid(outValid), .done(done),
  .localId(localId), .groupId(groupId), .groupSize(groupSize),
  .groupCount(groupCount), .localIndex(localIndex)
);

// File: tb/test_dispatch_id_gen.sv
module test_dispatch_id_gen;

  localparam int DW = 4;
  localparam int GW = 2 * DW;

  logic              clk = 1'b0;
  logic              rstN = 1'b0;
  logic              start = 1'b0;
  logic [1:0]        cfgDims = 2'd3;
  logic [3*DW-1:0]   cfgSize = '0;
  logic [3*DW-1:0]   cfgCount = '0;
  logic              outReady = 1'b0;
  logic              outValid, done;
  logic [3*DW-1:0]   localId, groupId, groupSize, groupCount, localIndex;
  logic [6*DW-1:0]   globalId;

  int checks = 0;
  int failures = 0;

  always #5 clk = ~clk;

  dispatch_id_gen #(.DIM_W(DW)) i_dispatch_id_gen (
    .clk(clk), .rstN(rstN), .start(start), .cfgDims(cfgDims),
    .cfgSize(cfgSize), .cfgCount(cfgCount), .outReady(outReady),
    .outValid(outValid), .localId(localId), .groupId(groupId),
    .globalId(globalId), .groupSize(groupSize), .groupCount(groupCount),
    .localIndex(localIndex), .done(done)
  );

  task automatic chk(input string req, input string what, input longint act, input longint exp);
    checks++;
    if (act != exp) begin
      failures++;
      $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, exp);
    end
  endtask

  function automatic logic [3*DW-1:0] pack3(input int x, input int y, input int z);
    return {DW'(z), DW'(y), DW'(x)};
  endfunction

  task automatic runDisp(input logic [1:0] dims, input int sx, input int sy, input int sz,
                         input int cx, input int cy, input int cz,
                         input bit rndReady, input bit poke);
    int es[3];
    int ec[3];
    bit zero;
    es = '{sx, sy, sz};
    ec = '{cx, cy, cz};
    if (dims == 2'd1) begin es[1] = 1; es[2] = 1; ec[1] = 1; ec[2] = 1; end
    if (dims == 2'd2) begin es[2] = 1; ec[2] = 1; end
    zero = 0;
    for (int i = 0; i < 3; i++) if (es[i] == 0 || ec[i] == 0) zero = 1;

    @(negedge clk);
    cfgDims = dims; cfgSize = pack3(sx, sy, sz); cfgCount = pack3(cx, cy, cz);
    start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    if (zero) begin
      chk("R9", "done after empty start", done, 1);
      chk("R9", "valid after empty start", outValid, 0);
      @(negedge clk);
      chk("R9", "done falls", done, 0);
      chk("R9", "valid stays low", outValid, 0);
      return;
    end
    for (int gz = 0; gz < ec[2]; gz++)
    for (int gy = 0; gy < ec[1]; gy++)
    for (int gx = 0; gx < ec[0]; gx++)
    for (int lz = 0; lz < es[2]; lz++)
    for (int ly = 0; ly < es[1]; ly++)
    for (int lx = 0; lx < es[0]; lx++) begin
      bit acc = 0;
      int waitN = 0;
      while (!acc) begin
        string tag;
        tag = (waitN > 0) ? "R7" : "R2";
        outReady = rndReady ? ($urandom_range(0, 2) != 0) : 1'b1;
        // R10: start with another configuration during the walk
        if (poke && gx == 0 && gy == 0 && gz == 0 && lx == 0 && ly == 0 && lz == 0
            && waitN == 0) begin
          start = 1'b1; cfgDims = 2'd1; cfgSize = pack3(2, 0, 0); cfgCount = pack3(1, 0, 0);
        end
        chk(tag, "valid", outValid, 1);
        chk(tag, "done low during walk", done, 0);
        chk(tag, "localId (R11 packing)", localId, pack3(lx, ly, lz));
        chk(tag, "groupId", groupId, pack3(gx, gy, gz));
        chk("R3", "globalId.x", globalId[0 +: GW], gx * es[0] + lx);
        chk("R3", "globalId.y", globalId[GW +: GW], gy * es[1] + ly);
        chk("R3", "globalId.z", globalId[2*GW +: GW], gz * es[2] + lz);
        chk("R4", "localIndex", localIndex, lz * es[0] * es[1] + ly * es[0] + lx);
        chk(dims inside {2'd1, 2'd2} ? "R5" : "R6", "groupSize", groupSize,
            pack3(es[0], es[1], es[2]));
        chk(dims inside {2'd1, 2'd2} ? "R5" : "R6", "groupCount", groupCount,
            pack3(ec[0], ec[1], ec[2]));
        acc = outReady;
        @(negedge clk);
        if (start) chk("R10", "walk continues after ignored start", outValid, 1);
        start = 1'b0;
        waitN++;
      end
    end
    outReady = 1'b0;
    chk("R8", "done after last accept", done, 1);
    chk("R8", "valid low with done", outValid, 0);
    @(negedge clk);
    chk("R8", "done is one cycle", done, 0);
    chk("R8", "no extra invocation", outValid, 0);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    failures++;
    $display("FAIL watchdog expired actual=running expected=finished");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    chk("R1", "valid in reset", outValid, 0);
    chk("R1", "done in reset", done, 0);
    rstN = 1'b1;
    @(negedge clk);
    chk("R1", "valid after reset", outValid, 0);
    chk("R1", "done after reset", done, 0);
    // 8x4 groups on a 5x4 grid; includes global (10,9) = local (2,1), group (1,2)
    runDisp(2'd2, 8, 4, 9, 5, 4, 0, 1'b0, 1'b0);
    runDisp(2'd2, 8, 4, 0, 5, 4, 3, 1'b1, 1'b0);
    runDisp(2'd3, 3, 2, 2, 2, 2, 2, 1'b1, 1'b1);   // R10 poke
    runDisp(2'd1, 5, 7, 0, 3, 0, 9, 1'b1, 1'b0);   // R5 garbage on y/z
    runDisp(2'd0, 2, 3, 1, 1, 1, 2, 1'b0, 1'b0);
    runDisp(2'd3, 1, 1, 1, 1, 1, 1, 1'b1, 1'b0);   // single invocation
    runDisp(2'd3, 15, 1, 1, 1, 1, 1, 1'b0, 1'b0);  // full width x
    runDisp(2'd2, 0, 3, 1, 2, 2, 1, 1'b0, 1'b0);   // R9 zero size x
    runDisp(2'd1, 4, 1, 1, 0, 1, 1, 1'b0, 1'b0);   // R9 zero count x
    runDisp(2'd3, 2, 2, 2, 2, 2, 0, 1'b0, 1'b0);   // R9 zero count z
    runDisp(2'd2, 2, 2, 0, 2, 2, 0, 1'b1, 1'b0);   // zero z ignored in 2D
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

endmodule